// File: doc/BRIEF.md
# Dual-Output Interrupt Controller Register Bank

This block collects 32 interrupt request lines into one status word and presents it to software through a small register port. The port has a 4-bit word offset, 32-bit data, and separate read and write strobes. Each line is configured as either edge or level sensitive. Line `n` lands in status bit `31-n`.

Pending bits are masked by an enable word. A per-bit routing word then splits them between two outputs: a normal interrupt output and a critical interrupt output. Software clears status by writing ones. Bits whose level-sensitive line is still active come straight back. A second offset lets software raise status bits directly.

For the critical output, a separate vector unit turns the highest-priority critical bit into an address-style vector. The vector is a base taken from a configuration word plus a fixed 512-byte stride per bit. The scan direction is selectable. The parameter `VEC_EN` removes the vector unit. With `VEC_EN` at 0, offsets 7 and 8 read as zero.

Top module: `irq_router_bank`

## Requirements
- R1: After reset, every register reads zero at offsets 0 to 8, both interrupt outputs are low, and the level shadow is clear.
- R2: Line `n` drives status bit `31-n`. With its trigger-mode bit at 0 (level), a change on the line sets the status bit and the shadow bit to the new line value. Reads at offset 0 and at offset 1 both return status.
- R3: With its trigger-mode bit at 1 (edge), a rising transition on the line sets the status bit, and a falling line leaves it unchanged. A line held high that software has cleared stays clear until the line falls and rises again.
- R4: A write to offset 0 clears each status bit written as 1, then ORs the level shadow back in. A level line that is still high therefore keeps its bit.
- R5: A write to offset 1 ORs the written value into status.
- R6: Offset 2 holds the enable word, and offset 6 reads status AND enable. Writes to offset 6 or offset 7 change no register.
- R7: The normal output is registered and is high when status AND enable AND NOT critical-select (offset 3) is nonzero. It reflects a write or line change from the clock edge that samples it.
- R8: The critical output is registered and is high when status AND enable AND critical-select is nonzero, with the same timing as R7.
- R9: When critical bits are pending and configuration bit 0 is 0, the vector at offset 7 is (configuration AND 0xFFFFFFFC) plus 512 times the lowest pending critical status-bit index.
- R10: When critical bits are pending and configuration bit 0 is 1, the vector is (configuration AND 0xFFFFFFFC) plus 512 times (31 minus the highest pending critical status-bit index).
- R11: A write to offset 8 stores the value with bit 1 forced to 0. The vector reads zero whenever no critical bit is pending.
- R12: The polarity word at offset 4 reads back as written and changes neither output. Offsets 9 to 15 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines; line n maps to status bit 31-n |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; read data is zero while low |
| reg_rdata | output | 32 | Read data, combinational from the current registers |
| irq_norm | output | 1 | Normal interrupt output, registered |
| irq_crit | output | 1 | Critical interrupt output, registered |

## Verification
The bench clears status with all ones while a level line is held high. A design that forgot the shadow restore would lose that pending interrupt.

It clears an edge line while the line stays high and then waits. A design that re-armed on level rather than on a transition would set the bit again at once.

Both scan directions of the vector are checked with two pending critical bits. Swapping the lowest and highest search, or dropping the index reversal, gives a different vector.

Writes to the read-only offsets are followed by reads of the enable word, the masked status and the vector. A decoder that let such a write through would change one of them.

// File: rtl/irq_bank_pkg.sv
// Package: shared offsets for the interrupt register bank.
// Assumes a 4-bit word offset; values not listed here are unmapped.
package irq_bank_pkg;
    localparam int unsigned OFS_W = 4;

    typedef enum logic [OFS_W-1:0] {
        OFS_STAT  = 4'd0,
        OFS_SET   = 4'd1,
        OFS_EN    = 4'd2,
        OFS_CSEL  = 4'd3,
        OFS_POL   = 4'd4,
        OFS_TRIG  = 4'd5,
        OFS_MSTAT = 4'd6,
        OFS_VEC   = 4'd7,
        OFS_VCFG  = 4'd8
    } reg_ofs_e;
endpackage

// File: rtl/irq_status_core.sv
// Module: irq_status_core
// Holds the status word and the level shadow. Also samples the request lines
// for transitions. Line n maps to status bit N-1-n. Within one cycle, software
// writes are applied first and line events second.
// Assumes irq_in is synchronous to clk.
module irq_status_core #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] trig,
    input  logic         clr_we,
    input  logic         set_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] status_q,
    output logic [N-1:0] status_nxt
);
    logic [N-1:0] line_map;
    logic [N-1:0] line_q;
    logic [N-1:0] shadow_q;
    logic [N-1:0] shadow_nxt;
    logic [N-1:0] line_chg;
    logic [N-1:0] line_rise;
    logic [N-1:0] keep_bits;

    // Bit reversal: line n drives status bit N-1-n.
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_map
            assign line_map[N-1-g] = irq_in[g];
        end
    endgenerate

    assign line_chg  = line_map ^ line_q;
    assign line_rise = line_map & ~line_q;
    // Shadow bits that a clear write must restore this cycle.
    assign keep_bits = shadow_q & ~(~trig & line_chg);

    // Next status: software clear/set first, then line events per bit.
    always_comb begin
        status_nxt = status_q;
        shadow_nxt = shadow_q;
        if (clr_we) begin
            status_nxt = (status_nxt & ~wdata) | shadow_q;
        end
        if (set_we) begin
            status_nxt = status_nxt | wdata;
        end
        for (int b = 0; b < N; b++) begin
            if (trig[b]) begin
                status_nxt[b] = status_nxt[b] | line_rise[b];
            end else if (line_chg[b]) begin
                status_nxt[b] = line_map[b];
                shadow_nxt[b] = line_map[b];
            end
        end
    end

    // State registers: status, shadow and previous line sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            shadow_q <= '0;
            line_q   <= '0;
        end else begin
            status_q <= status_nxt;
            shadow_q <= shadow_nxt;
            line_q   <= line_map;
        end
    end

    AST_LEVEL_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((status_q & $past(keep_bits)) == $past(keep_bits))); // R4

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((status_q & $past(status_q & trig)) == $past(status_q & trig))); // R3
endmodule

// File: rtl/irq_vector_unit.sv
// Module: irq_vector_unit
// Turns the pending critical bits into a vector: base plus STEP times an index.
// With dir_desc low, the index is the lowest pending bit. With dir_desc high,
// it is N-1 minus the highest pending bit. The result is zero when nothing is
// pending. Purely combinational.
module irq_vector_unit #(
    parameter int unsigned N    = 32,
    parameter int unsigned STEP = 512
) (
    input  logic [N-1:0] crit_bits,
    input  logic [N-1:0] base,
    input  logic         dir_desc,
    output logic [N-1:0] vec
);
    localparam int unsigned IDXW = $clog2(N);
    localparam logic [N-1:0] STEP_V = N'(STEP);

    logic [IDXW-1:0] idx;

    // Priority scan; the last match in loop order wins.
    always_comb begin
        idx = '0;
        if (dir_desc) begin
            for (int i = 0; i < N; i++) begin
                if (crit_bits[i]) idx = IDXW'(N - 1 - i);
            end
        end else begin
            for (int i = N - 1; i >= 0; i--) begin
                if (crit_bits[i]) idx = IDXW'(i);
            end
        end
    end

    // Vector arithmetic, forced to zero when no critical bit is pending.
    always_comb begin
        if (crit_bits == '0) vec = '0;
        else                 vec = base + (N'(idx) * STEP_V);
    end
endmodule

// File: rtl/irq_router_bank.sv
// Module: irq_router_bank
// Register bank of the dual-output interrupt controller. It decodes the
// register port, keeps the configuration words and registers both outputs and
// the vector from next-state values. A write or line change is therefore seen
// at the outputs from the clock edge that samples it.
// Assumes single-cycle write strobes; reads are combinational.
module irq_router_bank
    import irq_bank_pkg::*;
#(
    parameter int unsigned N      = 32,
    parameter int unsigned STEP   = 512,
    parameter bit          VEC_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     irq_in,
    input  logic [OFS_W-1:0] reg_addr,
    input  logic [N-1:0]     reg_wdata,
    input  logic             reg_wr,
    input  logic             reg_rd,
    output logic [N-1:0]     reg_rdata,
    output logic             irq_norm,
    output logic             irq_crit
);
    localparam logic [N-1:0] VCFG_MASK = ~(N'(2));
    localparam logic [N-1:0] BASE_MASK = ~(N'(3));

    logic [N-1:0] enable_q, csel_q, pol_q, trig_q, vcfg_q, vec_q;
    logic [N-1:0] enable_nxt, csel_nxt, vcfg_nxt, vec_nxt;
    logic [N-1:0] status_q, status_nxt;
    logic         we_clr, we_set, we_en, we_csel, we_pol, we_trig, we_vcfg;
    reg_ofs_e     ofs;

    assign ofs     = reg_ofs_e'(reg_addr);
    assign we_clr  = reg_wr && (ofs == OFS_STAT);
    assign we_set  = reg_wr && (ofs == OFS_SET);
    assign we_en   = reg_wr && (ofs == OFS_EN);
    assign we_csel = reg_wr && (ofs == OFS_CSEL);
    assign we_pol  = reg_wr && (ofs == OFS_POL);
    assign we_trig = reg_wr && (ofs == OFS_TRIG);
    assign we_vcfg = reg_wr && (ofs == OFS_VCFG);

    irq_status_core #(.N(N)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .trig       (trig_q),
        .clr_we     (we_clr),
        .set_we     (we_set),
        .wdata      (reg_wdata),
        .status_q   (status_q),
        .status_nxt (status_nxt)
    );

    // Next values of the words that feed the outputs.
    always_comb begin
        enable_nxt = we_en   ? reg_wdata : enable_q;
        csel_nxt   = we_csel ? reg_wdata : csel_q;
        vcfg_nxt   = we_vcfg ? (reg_wdata & VCFG_MASK) : vcfg_q;
    end

    // Optional vector unit, chosen by VEC_EN.
    generate
        if (VEC_EN) begin : g_vec
            irq_vector_unit #(.N(N), .STEP(STEP)) u_vec (
                .crit_bits (status_nxt & enable_nxt & csel_nxt),
                .base      (vcfg_nxt & BASE_MASK),
                .dir_desc  (vcfg_nxt[0]),
                .vec       (vec_nxt)
            );
        end else begin : g_novec
            assign vec_nxt = '0;
        end
    endgenerate

    // Configuration words, vector and output flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            csel_q   <= '0;
            pol_q    <= '0;
            trig_q   <= '0;
            vcfg_q   <= '0;
            vec_q    <= '0;
            irq_norm <= 1'b0;
            irq_crit <= 1'b0;
        end else begin
            enable_q <= enable_nxt;
            csel_q   <= csel_nxt;
            vcfg_q   <= vcfg_nxt;
            vec_q    <= vec_nxt;
            if (we_pol)  pol_q  <= reg_wdata;
            if (we_trig) trig_q <= reg_wdata;
            irq_norm <= |(status_nxt & enable_nxt & ~csel_nxt);
            irq_crit <= |(status_nxt & enable_nxt & csel_nxt);
        end
    end

    // Read multiplexer; zero when no read strobe or unmapped offset.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (ofs)
                OFS_STAT, OFS_SET: reg_rdata = status_q;
                OFS_EN:            reg_rdata = enable_q;
                OFS_CSEL:          reg_rdata = csel_q;
                OFS_POL:           reg_rdata = pol_q;
                OFS_TRIG:          reg_rdata = trig_q;
                OFS_MSTAT:         reg_rdata = status_q & enable_q;
                OFS_VEC:           reg_rdata = VEC_EN ? vec_q : '0;
                OFS_VCFG:          reg_rdata = VEC_EN ? vcfg_q : '0;
                default:           reg_rdata = '0;
            endcase
        end
    end

    AST_NORM_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_norm == |(status_q & enable_q & ~csel_q)); // R7

    AST_CRIT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_crit == |(status_q & enable_q & csel_q)); // R8

    AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_crit |-> (vec_q == '0)); // R11

    AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (ofs == OFS_MSTAT || ofs == OFS_VEC)) |=>
        ($stable(enable_q) && $stable(csel_q) && $stable(trig_q) && $stable(vcfg_q))); // R6
endmodule

// File: tb/irq_router_bank_test.sv
// Directed bench for irq_router_bank: one task per scenario.
module irq_router_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq_norm, irq_crit;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    irq_router_bank uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .irq_norm(irq_norm), .irq_crit(irq_crit)
    );

    always #10 clk = ~clk; // 50 MHz

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #2;
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic drive(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), d);
            check($sformatf("R1 offset %0d", a), d, 32'h0);
        end
        check("R1 norm", {31'b0, irq_norm}, 32'h0);
        check("R1 crit", {31'b0, irq_crit}, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(4'd2, 32'hFFFF_FFFF);
        drive(32'h0000_0008);
        rd(4'd0, d); check("R2 line3 -> bit28", d, 32'h1000_0000);
        rd(4'd1, d); check("R2 offset1 reads status", d, 32'h1000_0000);
        check("R7 norm high", {31'b0, irq_norm}, 32'h1);
        rd(4'd6, d); check("R6 masked status", d, 32'h1000_0000);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, d); check("R4 level restore", d, 32'h1000_0000);
        wr(4'd1, 32'h0000_0001);
        rd(4'd0, d); check("R5 set bit0", d, 32'h1000_0001);
        wr(4'd0, 32'h0000_0001);
        rd(4'd0, d); check("R4 clear set bit", d, 32'h1000_0000);
        drive(32'h0);
        rd(4'd0, d); check("R2 level follows low", d, 32'h0);
        check("R7 norm low", {31'b0, irq_norm}, 32'h0);
        drive(32'h8000_0000);
        rd(4'd0, d); check("R2 line31 -> bit0", d, 32'h0000_0001);
        drive(32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(4'd5, 32'hFFFF_FFFF);
        drive(32'h0000_0020);
        rd(4'd0, d); check("R3 rise sets bit26", d, 32'h0400_0000);
        drive(32'h0);
        rd(4'd0, d); check("R3 fall keeps bit", d, 32'h0400_0000);
        drive(32'h0000_0020);
        wr(4'd0, 32'h0400_0000);
        rd(4'd0, d); check("R3 clear while held", d, 32'h0);
        repeat (3) @(negedge clk);
        rd(4'd0, d); check("R3 no re-set while held", d, 32'h0);
        drive(32'h0);
        drive(32'h0000_0020);
        rd(4'd0, d); check("R3 new rise sets", d, 32'h0400_0000);
        drive(32'h0);
    endtask

    task automatic t_crit();
        logic [31:0] d;
        wr(4'd3, 32'h0400_0000);
        check("R8 crit high", {31'b0, irq_crit}, 32'h1);
        check("R7 norm low when routed", {31'b0, irq_norm}, 32'h0);
        wr(4'd2, 32'hFBFF_FFFF);
        check("R8 crit masked", {31'b0, irq_crit}, 32'h0);
        rd(4'd6, d); check("R6 masked status zero", d, 32'h0);
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd3, 32'h0);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, d); check("R4 edge bits cleared", d, 32'h0);
    endtask

    task automatic t_vector();
        logic [31:0] d;
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd8, 32'h0001_0002);
        rd(4'd8, d); check("R11 bit1 forced low", d, 32'h0001_0000);
        wr(4'd1, 32'h0000_0030);
        check("R8 crit high", {31'b0, irq_crit}, 32'h1);
        rd(4'd7, d); check("R9 ascending vector", d, 32'h0001_0800);
        wr(4'd8, 32'h0001_0001);
        rd(4'd8, d); check("R11 config readback", d, 32'h0001_0001);
        rd(4'd7, d); check("R10 descending vector", d, 32'h0001_3400);
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd6, 32'hFFFF_FFFF);
        rd(4'd7, d); check("R6 vector write ignored", d, 32'h0001_3400);
        rd(4'd6, d); check("R6 masked write ignored", d, 32'h0000_0030);
        rd(4'd2, d); check("R6 enable unchanged", d, 32'hFFFF_FFFF);
        wr(4'd0, 32'h0000_0030);
        rd(4'd7, d); check("R11 vector zero when idle", d, 32'h0);
        check("R8 crit low", {31'b0, irq_crit}, 32'h0);
    endtask

    task automatic t_misc();
        logic [31:0] d;
        wr(4'd4, 32'hA5A5_5A5A);
        rd(4'd4, d); check("R12 polarity readback", d, 32'hA5A5_5A5A);
        check("R12 norm unaffected", {31'b0, irq_norm}, 32'h0);
        check("R12 crit unaffected", {31'b0, irq_crit}, 32'h0);
        rd(4'd9, d);  check("R12 offset9 zero", d, 32'h0);
        rd(4'd15, d); check("R12 offset15 zero", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_level();
        t_edge();
        t_crit();
        t_vector();
        t_misc();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule